// File: doc/BRIEF.md
# Serial flash write-protection gate

This block sits behind the serial command decoder of a flash device and rules on every data-modifying command once chip select has risen. The decoder hands it a one-cycle `cmd_valid` strobe with the command code, the 22-bit address, the number of serial clocks counted while chip select was low, and the data byte for a status write. The gate answers one cycle later with either an `accept` pulse or a `reject` pulse and the target sector. It holds the write enable latch, the three block-protect bits and the status-freeze bit, and it presents them as a status byte.

The control is a four-state machine. `ST_HOLDOFF` is entered at reset and lasts until the power-up timer expires (`HOLDOFF_DONE` leads to `ST_IDLE`). `ST_IDLE` is the only state where commands are accepted. An accepted command leads to `ST_BUSY` (`ACCEPTED`), and the external `op_done` strobe leads back to `ST_IDLE` (`COMPLETED`). The deep power-down code in `ST_IDLE` leads to `ST_SLEEP` (`SLEEP_ENTER`), and only the release code leads back to `ST_IDLE` (`SLEEP_EXIT`). In any state other than `ST_IDLE`, a modifying command is answered with `reject`.

The protected region is always an upper slice of the 64 sectors. Its size doubles with each step of the three-bit protect code, except that code 0 protects nothing and code 7 protects everything.

Top module: `wp_gate`

## Requirements
- R1: For `HOLD_CYCLES` cycles after reset the gate stays in `ST_HOLDOFF`. Every modifying command gets `reject`, and write enable (0x06) has no effect on the status byte.
- R2: Write enable (code 0x06) in `ST_IDLE` sets status bit 1 (WEL). Write disable (code 0x04) in `ST_IDLE` clears it. Reset clears it.
- R3: A modifying command issued while WEL is 0 gets `reject`.
- R4: The modifying commands are status write 0x01, page program 0x02, sector erase 0xD8 and bulk erase 0xC7. Each gets `reject` unless `cmd_bits` is a nonzero multiple of eight.
- R5: With protect code P (status bits 4:2), a program or sector erase to sector S = `cmd_addr[21:16]` gets `reject` when S falls in the protected range. P=0 protects none, P=1 protects 63, P=2 protects 62..63, P=3 protects 60..63, P=4 protects 56..63, P=5 protects 48..63, P=6 protects 32..63, and P=7 protects all sectors.
- R6: Bulk erase is accepted only when the protect code is 000.
- R7: While status bit 7 (freeze) is 1 and `wp_n` is low, a status write gets `reject` and the protect bits and freeze bit keep their values.
- R8: An accepted status write loads status bit 7 from data bit 7 and bits 4:2 from data bits 4:2. Status bits 6:5 always read 0.
- R9: After `accept`, status bit 0 (busy) is 1 until `op_done`. One cycle after `op_done`, busy and WEL read 0. A rejected command leaves WEL unchanged.
- R10: In `ST_BUSY`, modifying commands get `reject` and write enable or disable leave the status byte unchanged.
- R11: Deep power-down (0xB9) in `ST_IDLE` enters `ST_SLEEP`. There, modifying commands get `reject` and every other code except release (0xAB) is ignored. Release returns the gate to `ST_IDLE` with WEL preserved.
- R12: The decision appears as a one-cycle `accept` or `reject` in the cycle after `cmd_valid`, never both at once, with `target_sector` equal to the sector of that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: a decoded command ended with chip select rising |
| cmd_code | input | 8 | Command code |
| cmd_addr | input | ADDR_W | Command address |
| cmd_bits | input | CNT_W | Serial clocks counted while chip select was low |
| cmd_sr_data | input | 8 | Data byte of a status write |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| op_done | input | 1 | Program, erase or status write finished |
| accept | output | 1 | Command accepted, one-cycle pulse |
| reject | output | 1 | Modifying command refused, one-cycle pulse |
| target_sector | output | SECT_W | Sector of the decided command |
| busy | output | 1 | An accepted operation is in progress |
| status | output | 8 | {freeze, 0, 0, protect[2:0], WEL, busy} |

## Verification
The bench builds the gate with `HOLD_CYCLES` = 16 instead of the large default. That lets it issue commands both inside and just after the power-up window within a few dozen cycles. It keeps the default six sector bits and 22-bit address, so every protect code from 1 to 6 can be checked at its exact lower boundary sector and at the sector just below it. Operation completion is driven by hand, which lets the bench probe the busy state before releasing it.

// File: rtl/wp_gate_pkg.sv
package wp_gate_pkg;

    typedef enum logic [1:0] {
        ST_HOLDOFF = 2'd0,
        ST_IDLE    = 2'd1,
        ST_BUSY    = 2'd2,
        ST_SLEEP   = 2'd3
    } gate_state_t;

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_WRSR   = 8'h01;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_SERASE = 8'hD8;
    localparam logic [7:0] OP_BERASE = 8'hC7;
    localparam logic [7:0] OP_SLEEP  = 8'hB9;
    localparam logic [7:0] OP_WAKE   = 8'hAB;

    function automatic logic is_modify(input logic [7:0] code);
        return (code == OP_WRSR) || (code == OP_PROG) ||
               (code == OP_SERASE) || (code == OP_BERASE);
    endfunction

endpackage

// File: rtl/wp_holdoff_timer.sv
module wp_holdoff_timer #(
    parameter int HOLD_CYCLES = 20000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CW = $clog2(HOLD_CYCLES + 2);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q != LIMIT)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q == LIMIT);

    // R1: the counter saturates at the hold-off length
    a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);
endmodule

// File: rtl/wp_sector_guard.sv
module wp_sector_guard #(
    parameter int SECT_W = 6
) (
    input  logic [2:0]        prot_code,
    input  logic [SECT_W-1:0] sector,
    output logic              is_protected
);
    localparam logic [SECT_W:0] TOTAL = (SECT_W+1)'(1) << SECT_W;

    logic [SECT_W:0] low_bound;

    always_comb begin
        low_bound = TOTAL - (TOTAL >> (3'd7 - prot_code));
        unique case (prot_code)
            3'd0:    is_protected = 1'b0;
            3'd7:    is_protected = 1'b1;
            default: is_protected = ({1'b0, sector} >= low_bound);
        endcase
    end
endmodule

// File: rtl/wp_count_check.sv
module wp_count_check #(
    parameter int CNT_W = 12
) (
    input  logic [CNT_W-1:0] bits,
    output logic             whole_bytes
);
    assign whole_bytes = (bits != '0) && (bits[2:0] == 3'b000);
endmodule

// File: rtl/wp_gate.sv
module wp_gate
    import wp_gate_pkg::*;
#(
    parameter int HOLD_CYCLES = 20000,
    parameter int ADDR_W      = 22,
    parameter int SECT_W      = 6,
    parameter int CNT_W       = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CNT_W-1:0]  cmd_bits,
    input  logic [7:0]        cmd_sr_data,
    input  logic              wp_n,
    input  logic              op_done,
    output logic              accept,
    output logic              reject,
    output logic [SECT_W-1:0] target_sector,
    output logic              busy,
    output logic [7:0]        status
);
    gate_state_t state_q, state_d;

    logic        hold_done;
    logic        sect_prot;
    logic        bits_ok;
    logic        mod_cmd;
    logic        allowed;
    logic        acc_c, rej_c;
    logic        wel_q, wel_d;
    logic        srwd_q;
    logic [2:0]  bp_q;
    logic [SECT_W-1:0] cmd_sector;

    assign cmd_sector = cmd_addr[ADDR_W-1 -: SECT_W];

    wp_holdoff_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .done (hold_done)
    );

    wp_sector_guard #(.SECT_W(SECT_W)) u_guard (
        .prot_code   (bp_q),
        .sector      (cmd_sector),
        .is_protected(sect_prot)
    );

    wp_count_check #(.CNT_W(CNT_W)) u_count (
        .bits       (cmd_bits),
        .whole_bytes(bits_ok)
    );

    // Per-command rule
    always_comb begin
        mod_cmd = is_modify(cmd_code);
        unique case (cmd_code)
            OP_WRSR:           allowed = !(srwd_q && !wp_n);
            OP_PROG,
            OP_SERASE:         allowed = !sect_prot;
            OP_BERASE:         allowed = (bp_q == 3'b000);
            default:           allowed = 1'b0;
        endcase
        acc_c = cmd_valid && (state_q == ST_IDLE) && mod_cmd &&
                wel_q && bits_ok && allowed;
        rej_c = cmd_valid && mod_cmd && !acc_c;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLDOFF: if (hold_done) state_d = ST_IDLE;
            ST_IDLE: begin
                if (acc_c)
                    state_d = ST_BUSY;
                else if (cmd_valid && cmd_code == OP_SLEEP)
                    state_d = ST_SLEEP;
            end
            ST_BUSY:    if (op_done) state_d = ST_IDLE;
            ST_SLEEP:   if (cmd_valid && cmd_code == OP_WAKE) state_d = ST_IDLE;
        endcase
    end

    // Write enable latch
    always_comb begin
        wel_d = wel_q;
        if (state_q == ST_BUSY && op_done)
            wel_d = 1'b0;
        else if (state_q == ST_IDLE && cmd_valid) begin
            if (cmd_code == OP_WREN)
                wel_d = 1'b1;
            else if (cmd_code == OP_WRDI)
                wel_d = 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_HOLDOFF;
        else
            state_q <= state_d;
    end

    // Outputs and status bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            accept        <= 1'b0;
            reject        <= 1'b0;
            target_sector <= '0;
            wel_q         <= 1'b0;
            srwd_q        <= 1'b0;
            bp_q          <= 3'b000;
        end else begin
            accept <= acc_c;
            reject <= rej_c;
            if (cmd_valid && mod_cmd)
                target_sector <= cmd_sector;
            wel_q <= wel_d;
            if (acc_c && cmd_code == OP_WRSR) begin
                srwd_q <= cmd_sr_data[7];
                bp_q   <= cmd_sr_data[4:2];
            end
        end
    end

    assign busy   = (state_q == ST_BUSY);
    assign status = {srwd_q, 2'b00, bp_q, wel_q, busy};

    // R12: never both decisions at once
    a_r12_one_decision: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && reject));
    // R3: an acceptance requires a set latch on the deciding cycle
    a_r3_accept_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(wel_q));
    // R9: an acceptance always lands in the busy state
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> busy);
    // R9: completion clears the latch
    a_r9_done_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_done) |=> (!wel_q && !busy));
    // R6: bulk erase only with an all-zero protect code
    a_r6_bulk_unprotected: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && $past(cmd_code) == OP_BERASE) |-> ($past(bp_q) == 3'b000));
    // R5: no protected sector is ever accepted
    a_r5_protected_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ($past(cmd_code) == OP_PROG || $past(cmd_code) == OP_SERASE))
            |-> !$past(sect_prot));
    // R7: a frozen status register holds its protect fields
    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (srwd_q && !wp_n) |=> ($stable(bp_q) && $stable(srwd_q)));
    // R11: nothing is accepted out of power-down
    a_r11_sleep_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP) |=> !accept);
    // R1: nothing is accepted during hold-off
    a_r1_holdoff_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLDOFF) |=> !accept);
endmodule

// File: tb/wp_gate_tb.sv
module wp_gate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = 8'h00;
    logic [21:0] cmd_addr = '0;
    logic [11:0] cmd_bits = '0;
    logic [7:0]  cmd_sr_data = 8'h00;
    logic        wp_n = 1'b1;
    logic        op_done = 1'b0;
    logic        accept, reject, busy;
    logic [5:0]  target_sector;
    logic [7:0]  status;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    wp_gate #(.HOLD_CYCLES(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .cmd_bits(cmd_bits), .cmd_sr_data(cmd_sr_data),
        .wp_n(wp_n), .op_done(op_done), .accept(accept), .reject(reject),
        .target_sector(target_sector), .busy(busy), .status(status)
    );

    typedef struct packed {
        logic [7:0] code;
        logic [5:0] sec;
        logic [7:0] bits;
        logic [7:0] data;
        logic       wp;
        logic       acc;
        logic       rej;
        logic [7:0] sr;
        logic [3:0] req;
    } vec_t;

    // Tags: R2 R3 R4 R5 R6 R7 R8 R9
    localparam vec_t VECS [22] = '{
        '{8'h02, 6'd5,  8'd32, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 4'd3},
        '{8'h06, 6'd0,  8'd8,  8'h00, 1'b1, 1'b0, 1'b0, 8'h02, 4'd2},
        '{8'h02, 6'd5,  8'd33, 8'h00, 1'b1, 1'b0, 1'b1, 8'h02, 4'd4},
        '{8'h02, 6'd5,  8'd0,  8'h00, 1'b1, 1'b0, 1'b1, 8'h02, 4'd4},
        '{8'h02, 6'd5,  8'd40, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 4'd9},
        '{8'h06, 6'd0,  8'd8,  8'h00, 1'b1, 1'b0, 1'b0, 8'h02, 4'd2},
        '{8'h01, 6'd0,  8'd16, 8'h04, 1'b1, 1'b1, 1'b0, 8'h04, 4'd8},
        '{8'h06, 6'd0,  8'd8,  8'h00, 1'b1, 1'b0, 1'b0, 8'h06, 4'd2},
        '{8'hD8, 6'd63, 8'd32, 8'h00, 1'b1, 1'b0, 1'b1, 8'h06, 4'd5},
        '{8'hD8, 6'd62, 8'd32, 8'h00, 1'b1, 1'b1, 1'b0, 8'h04, 4'd5},
        '{8'h06, 6'd0,  8'd8,  8'h00, 1'b1, 1'b0, 1'b0, 8'h06, 4'd2},
        '{8'hC7, 6'd0,  8'd8,  8'h00, 1'b1, 1'b0, 1'b1, 8'h06, 4'd6},
        '{8'h01, 6'd0,  8'd16, 8'hFF, 1'b1, 1'b1, 1'b0, 8'h9C, 4'd8},
        '{8'h06, 6'd0,  8'd8,  8'h00, 1'b1, 1'b0, 1'b0, 8'h9E, 4'd2},
        '{8'hD8, 6'd0,  8'd32, 8'h00, 1'b1, 1'b0, 1'b1, 8'h9E, 4'd5},
        '{8'h01, 6'd0,  8'd16, 8'h00, 1'b0, 1'b0, 1'b1, 8'h9E, 4'd7},
        '{8'h01, 6'd0,  8'd16, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 4'd7},
        '{8'h06, 6'd0,  8'd8,  8'h00, 1'b1, 1'b0, 1'b0, 8'h02, 4'd2},
        '{8'hC7, 6'd0,  8'd8,  8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 4'd6},
        '{8'h06, 6'd0,  8'd8,  8'h00, 1'b1, 1'b0, 1'b0, 8'h02, 4'd2},
        '{8'h04, 6'd0,  8'd8,  8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 4'd2},
        '{8'h02, 6'd5,  8'd32, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 4'd3}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic send(input [7:0] code, input [5:0] sec, input [11:0] bits,
                        input [7:0] data, input wpv);
        @(negedge clk);
        cmd_valid   = 1'b1;
        cmd_code    = code;
        cmd_addr    = {sec, 16'h1234};
        cmd_bits    = bits;
        cmd_sr_data = data;
        wp_n        = wpv;
        @(negedge clk);
        cmd_valid   = 1'b0;
    endtask

    task automatic complete();
        @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    function automatic int first_protected(input int p);
        case (p)
            2: return 62;
            3: return 60;
            4: return 56;
            5: return 48;
            default: return 32;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state, R2 and R1
        check(status == 8'h00, "R2 reset status", status, 8'h00);
        check(!accept && !reject, "R12 reset outputs", {accept, reject}, 0);
        // R1: hold-off window
        send(8'h06, 6'd0, 12'd8, 8'h00, 1'b1);
        check(status == 8'h00, "R1 write enable ignored", status, 8'h00);
        send(8'h02, 6'd1, 12'd32, 8'h00, 1'b1);
        check(reject && !accept, "R1 program refused", {accept, reject}, 1);
        repeat (30) @(negedge clk);

        // Table walk
        foreach (VECS[i]) begin
            vec_t v;
            string tag;
            v = VECS[i];
            tag = $sformatf("R%0d vec %0d", v.req, i);
            send(v.code, v.sec, {4'd0, v.bits}, v.data, v.wp);
            check(accept == v.acc && reject == v.rej, {tag, " decision"},
                  {accept, reject}, {v.acc, v.rej});
            if (v.acc || v.rej)
                check(target_sector == v.sec, "R12 target sector", target_sector, v.sec);
            if (v.acc) begin
                check(status[0] == 1'b1, "R9 busy after accept", status, 1);
                complete();
            end
            check(status == v.sr, {tag, " status"}, status, v.sr);
        end

        // R5: boundaries for each intermediate protect code
        for (int p = 2; p <= 6; p++) begin
            int b;
            b = first_protected(p);
            send(8'h06, 6'd0, 12'd8, 8'h00, 1'b1);
            send(8'h01, 6'd0, 12'd16, 8'(p << 2), 1'b1);
            complete();
            check(status == 8'(p << 2), "R8 protect load", status, p << 2);
            send(8'h06, 6'd0, 12'd8, 8'h00, 1'b1);
            send(8'hD8, 6'(b), 12'd32, 8'h00, 1'b1);
            check(reject && !accept, "R5 first protected sector", {accept, reject}, 1);
            send(8'h02, 6'(b - 1), 12'd2048, 8'h00, 1'b1);
            check(accept && !reject, "R5 sector below range", {accept, reject}, 2);
            complete();
        end
        send(8'h06, 6'd0, 12'd8, 8'h00, 1'b1);
        send(8'h01, 6'd0, 12'd16, 8'h00, 1'b1);
        complete();
        check(status == 8'h00, "R8 protect cleared", status, 8'h00);

        // R10: busy refusals
        send(8'h06, 6'd0, 12'd8, 8'h00, 1'b1);
        send(8'h02, 6'd3, 12'd32, 8'h00, 1'b1);
        check(accept, "R10 setup accept", accept, 1);
        check(status == 8'h03, "R10 busy status", status, 8'h03);
        send(8'hD8, 6'd1, 12'd32, 8'h00, 1'b1);
        check(reject && !accept, "R10 erase while busy", {accept, reject}, 1);
        send(8'h04, 6'd0, 12'd8, 8'h00, 1'b1);
        check(status == 8'h03, "R10 disable ignored while busy", status, 8'h03);
        complete();
        check(status == 8'h00, "R9 completion clears", status, 8'h00);

        // R11: deep power-down
        send(8'h06, 6'd0, 12'd8, 8'h00, 1'b1);
        send(8'hB9, 6'd0, 12'd8, 8'h00, 1'b1);
        check(status == 8'h02, "R11 sleep status", status, 8'h02);
        send(8'h02, 6'd1, 12'd32, 8'h00, 1'b1);
        check(reject && !accept, "R11 program while asleep", {accept, reject}, 1);
        send(8'h04, 6'd0, 12'd8, 8'h00, 1'b1);
        check(status == 8'h02, "R11 disable ignored asleep", status, 8'h02);
        send(8'hAB, 6'd0, 12'd8, 8'h00, 1'b1);
        send(8'h02, 6'd1, 12'd32, 8'h00, 1'b1);
        check(accept && !reject, "R11 program after release", {accept, reject}, 2);
        complete();

        // R2: reset clears the latch
        send(8'h06, 6'd0, 12'd8, 8'h00, 1'b1);
        check(status == 8'h02, "R2 set before reset", status, 8'h02);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(status == 8'h00, "R2 cleared by reset", status, 8'h00);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule